// File: doc/BRIEF.md
# Comparator-Driven Offset Calibration Controller

This controller removes the DC offset of an amplifier in closed loop. Its only measurement is one comparator bit that reports whether the amplifier output lies above or below ground. The controller drives a 16-bit correction DAC code and moves it by exactly one LSB per decision, toward the side the comparator asks for. After every move it waits a programmable settling interval so the analog path can follow before the comparator is read again.

A calibration starts with a start pulse and ends in one of three ways. The code dithers around the null point for a programmable number of consecutive direction reversals, which counts as convergence. The code reaches one end of its range while still being pushed outward, which counts as saturation. Or the step budget runs out, which counts as a timeout. The last code stays on the DAC until the next start. The comparator bit passes through a two-flop synchronizer before the controller uses it. The DAC load strobe marks every code update, so a serialiser further downstream knows when to send a word.

Top module: `offset_cal_ctrl`

## Requirements
- R1: After reset, `dac_code` is 32768 and `busy`, `dac_load`, `done`, `saturated` and `timeout` are all low.
- R2: A start pulse while idle sets `dac_code` to 32768, gives one `dac_load` pulse in the next cycle, raises `busy`, and clears `saturated` and `timeout`.
- R3: Every later `dac_load` marks a code change of exactly one LSB: up by one when the synchronized comparator reads 1, down by one when it reads 0. The code never changes without `dac_load`.
- R4: Consecutive `dac_load` pulses within one calibration are exactly `cfg_settle`+1 cycles apart. The comparator reaches the decision through two flops, so `cfg_settle` must be at least 2 for a decision to see the comparator's response to the newest code.
- R5: A decision whose direction is the opposite of the previous decision is a reversal. When the count of consecutive reversals reaches `cfg_rev_target`, the code freezes without a further step, `done` pulses high for exactly one cycle, and `busy` falls. A target of 0 behaves like 1.
- R6: A decision that would step above 65535 or below 0 leaves the code at that limit, raises `saturated` (held), and ends the calibration.
- R7: Once `cfg_max_steps` steps have been taken, the next decision that would step instead raises `timeout` (held) and ends the calibration with the code unchanged.
- R8: When several end conditions hold on the same decision, convergence wins over saturation, and saturation wins over timeout. Exactly one of `done`, `saturated`, `timeout` is raised per calibration.
- R9: A start pulse while `busy` is high has no effect on the code sequence, the number of loads or the outcome.
- R10: After a calibration ends, `dac_code`, `saturated` and `timeout` hold their values and no `dac_load` occurs until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration (ignored while busy) |
| comp_in | input | 1 | Asynchronous comparator bit, 1 asks for a higher code |
| cfg_settle | input | 16 | Settling wait after each code update, in cycles |
| cfg_max_steps | input | 16 | Maximum number of single-LSB steps per calibration |
| cfg_rev_target | input | 4 | Consecutive reversals that count as convergence |
| dac_code | output | 16 | Correction DAC code |
| dac_load | output | 1 | One-cycle strobe on each code update |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle pulse on convergence |
| saturated | output | 1 | Calibration ended at a code limit |
| timeout | output | 1 | Calibration ended on the step budget |

## Verification
A corrupted reversal counter or stale direction memory shows up as a final code one LSB away from the expected dither point, or as a wrong number of load strobes, and it is visible as soon as the calibration ends. A broken settle counter changes the spacing between load strobes, and the gap check catches it at the second load of a run. A wrapping or unclamped code register produces a jump of 65535 instead of 1 at the range edge, which the step-size property catches in that same cycle. A bad end-condition ordering raises the wrong flag on the final decision of the priority cases.

// File: rtl/offcal_pkg.sv
package offcal_pkg;

    // Controller sequencing state.
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_SETTLE = 1'b1
    } cal_state_e;

    // How a decision finishes the calibration, if at all.
    typedef enum logic [1:0] {
        END_NONE = 2'd0,
        END_CONV = 2'd1,
        END_SAT  = 2'd2,
        END_TMO  = 2'd3
    } cal_end_e;

    // Conditions evaluated on each decision.
    typedef struct packed {
        logic converge;   // reversal run reached target
        logic at_limit;   // requested step leaves the code range
        logic budget_out; // step budget exhausted
    } verdict_t;

    // Priority: convergence, then saturation, then timeout.
    function automatic cal_end_e pick_end(input verdict_t v);
        cal_end_e r;
        if (v.converge)        r = END_CONV;
        else if (v.at_limit)   r = END_SAT;
        else if (v.budget_out) r = END_TMO;
        else                   r = END_NONE;
        return r;
    endfunction

endpackage

// File: rtl/offcal_sync.sv
module offcal_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/offcal_settle.sv
module offcal_settle #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    assign expired = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (run && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/offcal_stepper.sv
module offcal_stepper #(
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              step,
    input  logic              up,
    output logic [CODE_W-1:0] code,
    output logic              at_top,
    output logic              at_bot
);
    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    assign at_top = (code == {CODE_W{1'b1}});
    assign at_bot = (code == '0);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            code <= MID_CODE;
        end else if (step) begin
            if (up) code <= code + 1'b1;
            else    code <= code - 1'b1;
        end
    end
endmodule

// File: rtl/offcal_reversal.sv
module offcal_reversal #(
    parameter int REV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             decide,
    input  logic             dir,
    input  logic [REV_W-1:0] target,
    output logic             converge
);
    logic             have_dir;
    logic             prev_dir;
    logic [REV_W-1:0] run_cnt;
    logic             reversed;
    logic [REV_W-1:0] run_next;

    assign reversed = have_dir && (dir != prev_dir);

    always_comb begin
        if (!reversed)                 run_next = '0;
        else if (run_cnt == '1)        run_next = run_cnt;
        else                           run_next = run_cnt + 1'b1;
    end

    assign converge = reversed && (run_next >= target);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            have_dir <= 1'b0;
            prev_dir <= 1'b0;
            run_cnt  <= '0;
        end else if (decide) begin
            have_dir <= 1'b1;
            prev_dir <= dir;
            run_cnt  <= run_next;
        end
    end
endmodule

// File: rtl/offset_cal_ctrl.sv
module offset_cal_ctrl
    import offcal_pkg::*;
#(
    parameter int CODE_W      = 16,
    parameter int SETTLE_W    = 16,
    parameter int STEP_W      = 16,
    parameter int REV_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                comp_in,
    input  logic [SETTLE_W-1:0] cfg_settle,
    input  logic [STEP_W-1:0]   cfg_max_steps,
    input  logic [REV_W-1:0]    cfg_rev_target,
    output logic [CODE_W-1:0]   dac_code,
    output logic                dac_load,
    output logic                busy,
    output logic                done,
    output logic                saturated,
    output logic                timeout
);
    cal_state_e        state;
    logic              comp_s;
    logic              settle_hit;
    logic              at_top;
    logic              at_bot;
    logic              converge;
    logic [STEP_W-1:0] step_cnt;
    logic              launch;
    logic              decide;
    logic              move;
    verdict_t          verdict;
    cal_end_e          ending;

    offcal_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (comp_in),
        .q   (comp_s)
    );

    assign launch = (state == ST_IDLE) && start;
    assign decide = (state == ST_SETTLE) && settle_hit;

    assign verdict.converge   = converge;
    assign verdict.at_limit   = comp_s ? at_top : at_bot;
    assign verdict.budget_out = (step_cnt == cfg_max_steps);
    assign ending             = pick_end(verdict);
    assign move               = decide && (ending == END_NONE);

    offcal_settle #(.CNT_W(SETTLE_W)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .restart (launch || move),
        .run     (state == ST_SETTLE),
        .limit   (cfg_settle),
        .expired (settle_hit)
    );

    offcal_stepper #(.CODE_W(CODE_W)) u_step (
        .clk    (clk),
        .rst    (rst),
        .init   (launch),
        .step   (move),
        .up     (comp_s),
        .code   (dac_code),
        .at_top (at_top),
        .at_bot (at_bot)
    );

    offcal_reversal #(.REV_W(REV_W)) u_rev (
        .clk      (clk),
        .rst      (rst),
        .clear    (launch),
        .decide   (decide),
        .dir      (comp_s),
        .target   (cfg_rev_target),
        .converge (converge)
    );

    assign busy = (state == ST_SETTLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            dac_load  <= 1'b0;
            done      <= 1'b0;
            saturated <= 1'b0;
            timeout   <= 1'b0;
            step_cnt  <= '0;
        end else begin
            dac_load <= launch || move;
            done     <= 1'b0;
            if (launch) begin
                state     <= ST_SETTLE;
                saturated <= 1'b0;
                timeout   <= 1'b0;
                step_cnt  <= '0;
            end else if (decide) begin
                if (move) begin
                    step_cnt <= step_cnt + 1'b1;
                end else begin
                    state <= ST_IDLE;
                    unique case (ending)
                        END_CONV: done      <= 1'b1;
                        END_SAT:  saturated <= 1'b1;
                        END_TMO:  timeout   <= 1'b1;
                        default:  ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/offcal_checker.sv
module offcal_checker #(
    parameter int CODE_W   = 16,
    parameter int SETTLE_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic [SETTLE_W-1:0] cfg_settle,
    input logic [CODE_W-1:0]   dac_code,
    input logic                dac_load,
    input logic                busy,
    input logic                done,
    input logic                saturated,
    input logic                timeout
);
    logic            past_ok = 1'b0;
    logic [SETTLE_W:0] gap;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                 gap <= '0;
        else if (dac_load)       gap <= {{SETTLE_W{1'b0}}, 1'b1};
        else if (gap != '1)      gap <= gap + 1'b1;
    end

    // R3: a load inside a run moves the code by one LSB, no wrap
    a_r3_unit_step: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (dac_load && $past(busy)) |->
            (({1'b0, dac_code} == {1'b0, $past(dac_code)} + 1'b1) ||
             ({1'b0, dac_code} + 1'b1 == {1'b0, $past(dac_code)})));

    // R3: no code change without a load strobe
    a_r3_no_silent_change: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !dac_load |-> $stable(dac_code));

    // R2: loads happen only inside a calibration
    a_r2_load_in_run: assert property (@(posedge clk) disable iff (rst)
        dac_load |-> busy);

    // R4: spacing between loads equals the settle setting plus one
    a_r4_settle_gap: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (dac_load && $past(busy)) |-> (gap == {1'b0, cfg_settle} + 1'b1));

    // R5: done lasts one cycle and only once idle
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6: saturation leaves the code at a range end
    a_r6_sat_at_limit: assert property (@(posedge clk) disable iff (rst)
        saturated |-> ((dac_code == '0) || (dac_code == '1)));

    // R8: one outcome per calibration
    a_r8_one_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, saturated, timeout}));

    // R10: idle code holds without a start
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(dac_code));
endmodule

bind offset_cal_ctrl offcal_checker #(.CODE_W(CODE_W), .SETTLE_W(SETTLE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cfg_settle (cfg_settle),
    .dac_code   (dac_code),
    .dac_load   (dac_load),
    .busy       (busy),
    .done       (done),
    .saturated  (saturated),
    .timeout    (timeout)
);

// File: tb/tb_offset_cal_ctrl.sv
module tb_offset_cal_ctrl;
    localparam int MIDC = 32768;
    localparam int TOPC = 65535;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        comp_in = 1'b0;
    logic [15:0] cfg_settle = 16'd2;
    logic [15:0] cfg_max_steps = 16'd100;
    logic [3:0]  cfg_rev_target = 4'd4;
    logic [15:0] dac_code;
    logic        dac_load, busy, done, saturated, timeout;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    int mode = 0;      // 0 analog model, 1 always high, 2 always low
    int target = MIDC;

    offset_cal_ctrl dut (
        .clk(clk), .rst(rst), .start(start), .comp_in(comp_in),
        .cfg_settle(cfg_settle), .cfg_max_steps(cfg_max_steps),
        .cfg_rev_target(cfg_rev_target), .dac_code(dac_code),
        .dac_load(dac_load), .busy(busy), .done(done),
        .saturated(saturated), .timeout(timeout)
    );

    always #10 clk = ~clk;

    // Comparator model: asks for a higher code while the code is below target.
    always @(negedge clk) begin
        if (mode == 1)      comp_in <= 1'b1;
        else if (mode == 2) comp_in <= 1'b0;
        else                comp_in <= (int'(dac_code) < target);
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_vec = n_vec + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_vec = n_vec + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference from the requirements. kind: 0 converged, 1 saturated, 2 timeout.
    function automatic void ref_run(input int tgt, input int md, input int rt, input int mx,
                                    output int fcode, output int moves, output int kind);
        int  c = MIDC;
        int  rev = 0;
        bit  have = 0;
        bit  prev = 0;
        bit  dir;
        bit  rv;
        moves = 0;
        kind = -1;
        while (kind < 0) begin
            dir = (md == 1) ? 1'b1 : (md == 2) ? 1'b0 : (c < tgt);
            rv = have && (dir != prev);
            rev = rv ? ((rev < 15) ? rev + 1 : 15) : 0;
            prev = dir;
            have = 1;
            if (rv && rev >= rt)                          kind = 0;
            else if ((dir && c == TOPC) || (!dir && c == 0)) kind = 1;
            else if (moves == mx)                         kind = 2;
            else begin
                c = dir ? c + 1 : c - 1;
                moves = moves + 1;
            end
        end
        fcode = c;
    endfunction

    task automatic run_case(input int s, input int tgt, input int md, input int rt,
                            input int mx, input bit poke);
        int  ecode, emoves, ekind;
        int  loads = 0;
        int  gap = 0;
        int  gap_bad = 0;
        int  n = 0;
        int  last_code;
        bit  fin = 0;
        ref_run(tgt, md, rt, mx, ecode, emoves, ekind);
        @(negedge clk);
        cfg_settle = 16'(s);
        cfg_max_steps = 16'(mx);
        cfg_rev_target = 4'(rt);
        target = tgt;
        mode = md;
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // first cycle after start: R2
        chk(dac_load && busy && int'(dac_code) == MIDC && !saturated && !timeout,
            "R2 start loads mid-scale", {dac_load, busy, saturated, timeout}, 4'b1100);
        loads = 1;
        while (!fin) begin
            @(negedge clk);
            n = n + 1;
            gap = gap + 1;
            if (poke && n == 1) start = 1'b1;
            if (poke && n == 2) start = 1'b0;
            if (dac_load) begin
                loads = loads + 1;
                if (gap != s + 1) gap_bad = gap_bad + 1;
                gap = 0;
            end
            if (!busy) fin = 1;
            if (n > 140000) begin
                chk(0, "R5 run ended", n, 140000);
                fin = 1;
            end
        end
        chk(done == (ekind == 0), "R5 done on final cycle", done, ekind == 0);
        chk(saturated == (ekind == 1), "R6 saturated flag", saturated, ekind == 1);
        chk(timeout == (ekind == 2), "R7 timeout flag", timeout, ekind == 2);
        chk(int'(dac_code) == ecode, poke ? "R9 final code with start poke" : "R8 final code",
            dac_code, ecode);
        chk(loads == emoves + 1, poke ? "R9 load count with start poke" : "R3 load count",
            loads, emoves + 1);
        chk(gap_bad == 0, "R4 load spacing", gap_bad, 0);
        last_code = int'(dac_code);
        @(negedge clk);
        chk(!done, "R5 done one cycle", done, 0);
        loads = 0;
        repeat (10) begin
            @(negedge clk);
            if (dac_load) loads = loads + 1;
        end
        chk(loads == 0 && int'(dac_code) == last_code &&
            saturated == (ekind == 1) && timeout == (ekind == 2),
            "R10 result holds", dac_code, last_code);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(int'(dac_code) == MIDC, "R1 reset code", dac_code, MIDC);
        chk(!busy && !dac_load && !done && !saturated && !timeout, "R1 reset flags",
            {busy, dac_load, done, saturated, timeout}, 0);

        // Directed corners
        run_case(3, MIDC + 5, 0, 4, 1000, 0);   // R5 converge above mid
        run_case(2, MIDC - 7, 0, 2, 1000, 0);   // R3 downward steps
        run_case(2, MIDC,     0, 0, 1000, 0);   // R5 target 0 acts as 1
        run_case(4, MIDC + 100, 0, 4, 10, 0);   // R7 timeout
        run_case(2, MIDC, 1, 4, 0, 0);          // R7 zero budget
        run_case(2, MIDC + 3, 0, 1, 3, 0);      // R8 converge beats timeout
        run_case(5, MIDC - 20, 0, 3, 1000, 1);  // R9 start while busy
        run_case(0, MIDC, 1, 4, 32767, 0);      // R6 and R8 top limit beats budget
        run_case(0, MIDC, 2, 4, 65535, 0);      // R6 bottom limit

        // Constrained random
        for (int i = 0; i < 20; i++) begin
            int s  = 2 + int'($urandom_range(3, 0));
            int tg = MIDC - 150 + int'($urandom_range(300, 0));
            int rt = 1 + int'($urandom_range(5, 0));
            int mx = (($urandom_range(3, 0)) == 0) ? int'($urandom_range(60, 1)) : 1000;
            bit pk = ($urandom_range(3, 0) == 0);
            run_case(s, tg, 0, rt, mx, pk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule